// File: doc/BRIEF.md
# Feedback-Loop Pulse Crossing

This block moves single-cycle event pulses from one clock domain into another clock domain that has no fixed relation to the first. Each pulse that arrives at the source side produces exactly one single-cycle pulse at the destination side. The two clocks may run at any ratio, provided the events are spaced as described below.

The source side has one register. On each sampled pulse it loads the inverse of the destination's first synchronizer stage, so every event turns into a level change. A loop closes across the two domains. The destination side passes that level through a chain of synchronizer flip-flops, and a registered XOR of the last two stages turns each level change back into a pulse. Only the first destination flip-flop ever samples the crossing signal. A parameter lengthens the chain when more time for metastability to settle is needed.

Events must be spaced by at least about `SYNC_STAGES` destination cycles plus one source cycle. Events closer together than that may merge into one.

Top module: `pulse_xfer`

## Requirements
- R1: Every `src_pulse` high at a rising `src_clk` edge, outside reset and correctly spaced, produces exactly one `dst_pulse` that is high for exactly one `dst_clk` cycle.
- R2: With the default `SYNC_STAGES` = 2, `dst_pulse` is high during the destination cycle that follows the 2nd rising `dst_clk` edge strictly after the `src_clk` edge that sampled the event.
- R3: When no event is sampled, the source register holds its value and `dst_pulse` stays low.
- R4: `rst` is asynchronous and active-high. It clears the source register, every synchronizer stage and `dst_pulse` to 0. An event that is still in flight when reset asserts is discarded and produces no output after release.
- R5: With `SYNC_STAGES` = 3, the XOR moves to stages 2 and 3. The output pulse then appears in the cycle after the 3rd rising `dst_clk` edge strictly after the sampling edge.
- R6: The number of destination pulses equals the number of source events. This holds whether the source clock is much faster than, a little faster than, close to, or slower than the destination clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| src_clk | input | 1 | Source domain clock |
| src_pulse | input | 1 | Single-cycle event in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_pulse | output | 1 | Registered single-cycle event in the destination domain |

## Verification
Three kinds of corrupted internal state show up at `dst_pulse`:
- A source register that flips without an event, or that fails to load the inverted feedback, shows up within `SYNC_STAGES` destination cycles. It appears either as an extra pulse or as a missing pulse, and the per-event count catches it.
- A synchronizer chain that skips or adds a stage moves the pulse by a whole destination cycle. The cycle-by-cycle comparison against the latency model flags this on the first event.
- A reset that misses any stage either leaves a stale toggle, which produces a pulse right after release, or loses the loop phase, which swallows the next event. Both are visible within a few destination cycles.

// File: rtl/pulse_xfer_pkg.sv
package pulse_xfer_pkg;
  // smallest legal synchronizer depth: one capture stage plus one compare stage
  localparam int unsigned MIN_STAGES = 2;
endpackage

// File: rtl/pulse_xfer_src.sv
// Source-domain register: turns each event into a level change by loading
// the inverse of the fed-back first destination stage.
module pulse_xfer_src (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic fb_i,
  output logic cross_o
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cross_o <= 1'b0;
    end else if (pulse_i) begin
      cross_o <= ~fb_i;
    end
  end
endmodule

// File: rtl/pulse_xfer_sync.sv
// Destination-domain synchronizer chain. Bit 0 is the only flop that samples
// the crossing signal; it must be kept as a single, unduplicated register.
module pulse_xfer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      q_o <= {q_o[STAGES-2:0], d_i};
    end
  end
endmodule

// File: rtl/pulse_xfer_edge.sv
// Registered change detector on two settled synchronizer stages.
module pulse_xfer_edge (
  input  logic clk,
  input  logic rst,
  input  logic newer_i,
  input  logic older_i,
  output logic pulse_o
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= newer_i ^ older_i;
    end
  end
endmodule

// File: rtl/pulse_xfer.sv
module pulse_xfer
  import pulse_xfer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rst,
  input  logic src_clk,
  input  logic src_pulse,
  input  logic dst_clk,
  output logic dst_pulse
);
  localparam int unsigned NUM_STAGES = (SYNC_STAGES < MIN_STAGES) ? MIN_STAGES : SYNC_STAGES;

  logic                  cross_q;
  logic [NUM_STAGES-1:0] stage_q;

  pulse_xfer_src u_src (
    .clk     (src_clk),
    .rst     (rst),
    .pulse_i (src_pulse),
    .fb_i    (stage_q[0]),
    .cross_o (cross_q)
  );

  pulse_xfer_sync #(.STAGES(NUM_STAGES)) u_sync (
    .clk (dst_clk),
    .rst (rst),
    .d_i (cross_q),
    .q_o (stage_q)
  );

  pulse_xfer_edge u_edge (
    .clk     (dst_clk),
    .rst     (rst),
    .newer_i (stage_q[NUM_STAGES-2]),
    .older_i (stage_q[NUM_STAGES-1]),
    .pulse_o (dst_pulse)
  );
endmodule

// File: rtl/pulse_xfer_chk.sv
module pulse_xfer_chk (
  input logic rst,
  input logic src_clk,
  input logic src_pulse,
  input logic src_q,
  input logic dst_clk,
  input logic sync_last,
  input logic dst_pulse
);
  // R1: an output pulse lasts one destination cycle
  a_r1_single_width: assert property (@(posedge dst_clk) disable iff (rst)
    dst_pulse |=> !dst_pulse);

  // R1: an output pulse always goes with a change of the last stage
  a_r1_out_needs_toggle: assert property (@(posedge dst_clk) disable iff (rst)
    dst_pulse |-> !$stable(sync_last));

  // R3: a change of the last stage is never silent
  a_r3_no_silent_toggle: assert property (@(posedge dst_clk) disable iff (rst)
    !$stable(sync_last) |-> dst_pulse);

  // R3: the source register holds when no event is sampled
  a_r3_src_hold: assert property (@(posedge src_clk) disable iff (rst)
    !src_pulse |=> $stable(src_q));

  // R4: reset holds the destination side cleared
  a_r4_reset_clear: assert property (@(posedge dst_clk)
    rst |-> (!dst_pulse && !sync_last));
endmodule

bind pulse_xfer pulse_xfer_chk u_chk (
  .rst       (rst),
  .src_clk   (src_clk),
  .src_pulse (src_pulse),
  .src_q     (cross_q),
  .dst_clk   (dst_clk),
  .sync_last (stage_q[NUM_STAGES-1]),
  .dst_pulse (dst_pulse)
);

// File: tb/test_pulse_xfer.sv
`timescale 1ps/1ps
module test_pulse_xfer;
  logic rst = 1'b0;
  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_pulse = 1'b0;
  logic out2, out3;

  int src_half = 1500;
  int vectors = 0;
  int errors = 0;
  int edges = 0;
  int pend2[$];
  int pend3[$];
  bit exp2 = 1'b0;
  bit exp3 = 1'b0;
  int seen2 = 0;
  int seen3 = 0;
  bit done = 1'b0;

  pulse_xfer i_pulse_xfer (
    .rst(rst), .src_clk(src_clk), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_pulse(out2)
  );

  pulse_xfer #(.SYNC_STAGES(3)) i_pulse_xfer_s3 (
    .rst(rst), .src_clk(src_clk), .src_pulse(src_pulse),
    .dst_clk(dst_clk), .dst_pulse(out3)
  );

  // 250 MHz destination clock; source half periods are odd multiples of 500 ps,
  // so source rising edges never coincide with destination rising edges
  always #2000 dst_clk = ~dst_clk;

  initial forever begin
    #(src_half) src_clk = 1'b1;
    #(src_half) src_clk = 1'b0;
  end

  // reference model: an event is due on the Nth destination edge after sampling
  always @(posedge src_clk) begin
    if (!rst && src_pulse) begin
      pend2.push_back(edges + 2);
      pend3.push_back(edges + 3);
    end
  end

  always @(posedge dst_clk) begin
    edges++;
    exp2 = 1'b0;
    exp3 = 1'b0;
    if (rst) begin
      pend2.delete();
      pend3.delete();
    end else begin
      if (pend2.size() > 0 && pend2[0] == edges) begin
        exp2 = 1'b1;
        void'(pend2.pop_front());
      end
      if (pend3.size() > 0 && pend3[0] == edges) begin
        exp3 = 1'b1;
        void'(pend3.pop_front());
      end
    end
  end

  // compare on every destination cycle, away from the active edge
  always @(negedge dst_clk) begin
    if (!done) begin
      vectors++;
      if (out2 !== exp2) begin
        errors++;
        $display("FAIL %s depth2 dst_pulse actual=%0b expected=%0b at %0t",
                 exp2 ? "R2" : "R3", out2, exp2, $time);
      end
      vectors++;
      if (out3 !== exp3) begin
        errors++;
        $display("FAIL R5 depth3 dst_pulse actual=%0b expected=%0b at %0t",
                 out3, exp3, $time);
      end
      if (out2 === 1'b1) seen2++;
      if (out3 === 1'b1) seen3++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv,
                       input string what);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic send_pulse();
    @(negedge src_clk) src_pulse = 1'b1;
    @(negedge src_clk) src_pulse = 1'b0;
  endtask

  task automatic run_phase(input int half, input int n);
    int base2, base3, b2, b3;
    @(negedge src_clk) src_half = half;
    repeat (2) @(negedge src_clk);
    base2 = seen2;
    base3 = seen3;
    for (int k = 0; k < n; k++) begin
      b2 = seen2;
      b3 = seen3;
      send_pulse();
      repeat (7) @(negedge dst_clk);
      repeat (2) @(negedge src_clk);
      check(seen2 - b2 == 1, "R1", seen2 - b2, 1, "depth2 pulses per event");
      check(seen3 - b3 == 1, "R1", seen3 - b3, 1, "depth3 pulses per event");
    end
    check(seen2 - base2 == n, "R6", seen2 - base2, n, "depth2 phase count");
    check(seen3 - base3 == n, "R6", seen3 - base3, n, "depth3 phase count");
  endtask

  initial begin
    #(200000 * 4000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int s2, s3;
    #100 rst = 1'b1;
    repeat (3) @(negedge dst_clk);
    check(out2 === 1'b0 && out3 === 1'b0, "R4", int'(out2 | out3), 0, "outputs in reset");
    #1000 rst = 1'b0;

    run_phase(1500, 10);   // source slightly faster than destination
    run_phase(500, 10);    // source much faster
    run_phase(5500, 10);   // source slower
    run_phase(2500, 10);   // source close to destination

    // reset with an event in flight: it must vanish
    @(negedge src_clk) src_half = 500;
    repeat (4) @(negedge src_clk);
    s2 = seen2;
    s3 = seen3;
    send_pulse();
    @(negedge dst_clk);
    #1000 rst = 1'b1;
    repeat (3) @(negedge dst_clk);
    #1000 rst = 1'b0;
    repeat (8) @(negedge dst_clk);
    check(seen2 == s2, "R4", seen2 - s2, 0, "depth2 pulses after reset discard");
    check(seen3 == s3, "R4", seen3 - s3, 0, "depth3 pulses after reset discard");

    // loop phase is restored after reset
    run_phase(1500, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule